// File: doc/BRIEF.md
# Decode Stage Flow Controller

This block sits between the fetch and rename stages of a multi-wide instruction pipeline. Each cycle it may accept a group of up to `SLOTS` pre-decoded instruction slots from fetch. It passes the surviving slots to rename, packed in order with a count. When rename cannot accept work, the arriving groups are parked in a group-wide skid buffer, and fetch is told to stall until that buffer has drained again.

Some slots can be checked without an execution unit. These are direct, unconditional transfers that read and write no registers, and slots predicted taken that are not control transfers at all. When one of them is found to be wrong, the controller forwards it, drops everything younger and sends a redirect pulse back to fetch. It then waits in a squashing state until commit and the reorder buffer both report that their own squash activity has ended. Eight free-running counters record how many cycles were spent in each state and how many of each decode event occurred.

Top module: `dec_stage_ctrl`

## Requirements
- R1: After reset the stall and redirect outputs are low, the rename slot count is 0 and all eight counters read 0.
- R2: While running with `rn_ready` high, an arriving group with count n is forwarded one cycle later. Each slot flag nibble uses bit0 = already squashed, bit1 = control transfer, bit2 = direct unconditional with no register operands, and bit3 = predicted taken. Non-squashed slots leave packed from slot 0 in their original order, and a resolvable slot whose predicted next PC equals its resolved target is forwarded with no redirect.
- R3: Slots whose bit0 is set are not forwarded, and each one adds 1 to the squashed-instruction counter.
- R4: With `rn_ready` low in the running or idle state, the arriving group, if any, is parked, nothing reaches rename and `fe_stall` is high after the edge. If `rn_ready` returns while the buffer is empty and no group arrives, `fe_stall` falls after that edge.
- R5: While blocked, every arriving group is parked even if `fe_stall` is high, up to `SKID_DEPTH` groups, and `fe_stall` stays high.
- R6: Once `rn_ready` is high again, parked groups leave the buffer one per cycle in arrival order, and groups arriving meanwhile are appended behind them. `fe_stall` stays high until the edge on which the last parked group leaves.
- R7: A slot with bit2 set whose predicted next PC differs from its resolved target is forwarded, and the slots after it are dropped. On the next edge `fe_squash` pulses with `fe_next_pc` equal to the resolved target, `fe_done_seq` equal to the slot's sequence number and `fe_ctrl_mis` low. The branch-mispredict counter then adds 1.
- R8: A slot with bit3 set and bit1 clear causes the same truncation and redirect, but with `fe_next_pc` equal to its PC plus `INST_BYTES` and `fe_ctrl_mis` high. The control-mispredict counter then adds 1.
- R9: After a redirect the stage remains squashing, and drops any arriving group, until `cm_squash` and `rob_squashing` are both low. It then returns to running.
- R10: `cm_squash` or `rob_squashing` high in any other state discards the arriving group and all parked groups, drops `fe_stall` and enters the squashing state.
- R11: The idle counter counts running or idle cycles with a fetch count of 0. The blocked, unblocking and squashing counters each count the cycles spent in their state.
- R12: The decoded-instruction counter adds the number of slots forwarded to rename.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fe_cnt | input | CW | Number of valid slots in the fetch group (0 = none) |
| fe_pc | input | SLOTS*PC_W | Slot PCs, slot i at bits [i*PC_W +: PC_W] |
| fe_pred_npc | input | SLOTS*PC_W | Predicted next PC of each slot |
| fe_seq | input | SLOTS*SEQ_W | Sequence number of each slot |
| fe_flags | input | SLOTS*4 | Per-slot flag nibble (see R2) |
| fe_target | input | SLOTS*PC_W | Resolved target of each slot |
| fe_stall | output | 1 | Stall request to fetch |
| fe_squash | output | 1 | One-cycle redirect pulse to fetch |
| fe_ctrl_mis | output | 1 | Redirect cause: 1 = non-control predicted taken, 0 = wrong target |
| fe_next_pc | output | PC_W | Fetch restart PC |
| fe_done_seq | output | SEQ_W | Sequence number of the offending slot |
| cm_squash | input | 1 | Squash in progress from commit |
| rob_squashing | input | 1 | Reorder buffer still squashing |
| rn_ready | input | 1 | Rename can accept a group |
| rn_cnt | output | CW | Number of valid slots sent to rename |
| rn_pc | output | SLOTS*PC_W | Forwarded slot PCs, packed from slot 0 |
| rn_seq | output | SLOTS*SEQ_W | Forwarded slot sequence numbers |
| pc_idle | output | CNT_W | Idle cycle counter |
| pc_blocked | output | CNT_W | Blocked cycle counter |
| pc_unblock | output | CNT_W | Unblocking cycle counter |
| pc_squash | output | CNT_W | Squashing cycle counter |
| pc_br_mis | output | CNT_W | Branch target mispredict counter |
| pc_ctl_mis | output | CNT_W | Control mispredict counter |
| pc_decoded | output | CNT_W | Forwarded instruction counter |
| pc_squashed | output | CNT_W | Skipped squashed-slot counter |

## Verification
The bench uses the default parameters: four slots per group, a four-group skid buffer, 32-bit PCs, 8-bit sequence numbers and 16-bit counters. With four slots, a single group can contain a skipped slot, a slot that resolves correctly and a slot that mispredicts with younger slots behind it. With four buffer entries, the bench can fill the buffer completely by pushing groups against the stall. It can also push and pop in the same cycle while the buffer is full, and drain five groups in order.

// File: rtl/dec_stage_pkg.sv
package dec_stage_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RUN    = 3'd1,
    ST_BLOCK  = 3'd2,
    ST_UNBLK  = 3'd3,
    ST_SQUASH = 3'd4
  } dec_state_e;

  localparam int FLAG_W      = 4;
  localparam int FL_SQUASHED = 0;
  localparam int FL_CTRL     = 1;
  localparam int FL_DIRECT   = 2;
  localparam int FL_PTAKEN   = 3;

  localparam int CT_IDLE     = 0;
  localparam int CT_BLOCKED  = 1;
  localparam int CT_UNBLOCK  = 2;
  localparam int CT_SQUASH   = 3;
  localparam int CT_BR_MIS   = 4;
  localparam int CT_CTL_MIS  = 5;
  localparam int CT_DECODED  = 6;
  localparam int CT_SQUASHED = 7;
  localparam int NUM_CTRS    = 8;

endpackage

// File: rtl/dec_skid_fifo.sv
module dec_skid_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  output logic [CW-1:0]    count
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;
  logic             full;
  logic             empty;
  logic             do_push;
  logic             do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !flush && (!full || pop);
  assign do_pop  = pop && !flush && !empty;
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !flush) |-> !full); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (pop && !flush) |-> !empty); // R6

endmodule

// File: rtl/dec_group_scan.sv
module dec_group_scan
  import dec_stage_pkg::*;
#(
  parameter int SLOTS      = 4,
  parameter int PC_W       = 32,
  parameter int SEQ_W      = 8,
  parameter int INST_BYTES = 4,
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic [CW-1:0]           in_cnt,
  input  logic [SLOTS*PC_W-1:0]   in_pc,
  input  logic [SLOTS*PC_W-1:0]   in_npc,
  input  logic [SLOTS*SEQ_W-1:0]  in_seq,
  input  logic [SLOTS*FLAG_W-1:0] in_flags,
  input  logic [SLOTS*PC_W-1:0]   in_tgt,
  output logic [CW-1:0]           keep_cnt,
  output logic [SLOTS*PC_W-1:0]   keep_pc,
  output logic [SLOTS*SEQ_W-1:0]  keep_seq,
  output logic [CW-1:0]           skip_cnt,
  output logic                    hit,
  output logic                    hit_ctrl,
  output logic [PC_W-1:0]         hit_pc,
  output logic [SEQ_W-1:0]        hit_seq
);

  always_comb begin
    int          idx;
    int          nskip;
    logic        stop;
    logic [FLAG_W-1:0] fl;
    logic [PC_W-1:0]   pc;
    idx      = 0;
    nskip    = 0;
    stop     = 1'b0;
    keep_pc  = '0;
    keep_seq = '0;
    hit      = 1'b0;
    hit_ctrl = 1'b0;
    hit_pc   = '0;
    hit_seq  = '0;
    for (int i = 0; i < SLOTS; i++) begin
      fl = in_flags[i*FLAG_W +: FLAG_W];
      pc = in_pc[i*PC_W +: PC_W];
      if ((CW'(i) < in_cnt) && !stop) begin
        if (fl[FL_SQUASHED]) begin
          nskip = nskip + 1;
        end else begin
          keep_pc[idx*PC_W +: PC_W]    = pc;
          keep_seq[idx*SEQ_W +: SEQ_W] = in_seq[i*SEQ_W +: SEQ_W];
          idx = idx + 1;
          if (fl[FL_PTAKEN] && !fl[FL_CTRL]) begin
            stop     = 1'b1;
            hit      = 1'b1;
            hit_ctrl = 1'b1;
            hit_pc   = pc + PC_W'(INST_BYTES);
            hit_seq  = in_seq[i*SEQ_W +: SEQ_W];
          end else if (fl[FL_DIRECT] &&
                       (in_npc[i*PC_W +: PC_W] != in_tgt[i*PC_W +: PC_W])) begin
            stop     = 1'b1;
            hit      = 1'b1;
            hit_pc   = in_tgt[i*PC_W +: PC_W];
            hit_seq  = in_seq[i*SEQ_W +: SEQ_W];
          end
        end
      end
    end
    keep_cnt = CW'(idx);
    skip_cnt = CW'(nskip);
  end

  always_comb begin
    AST_SCAN_CONSERVE: assert ((keep_cnt + skip_cnt) <= in_cnt); // R3
  end

endmodule

// File: rtl/dec_perf_ctrs.sv
module dec_perf_ctrs #(
  parameter int NUM   = 8,
  parameter int INC_W = 3,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [INC_W-1:0] inc [NUM],
  output logic [CNT_W-1:0] val [NUM]
);

  always_ff @(posedge clk) begin
    for (int g = 0; g < NUM; g++) begin
      if (rst) val[g] <= '0;
      else     val[g] <= val[g] + CNT_W'(inc[g]);
    end
  end

endmodule

// File: rtl/dec_stage_ctrl.sv
module dec_stage_ctrl
  import dec_stage_pkg::*;
#(
  parameter int SLOTS      = 4,
  parameter int PC_W       = 32,
  parameter int SEQ_W      = 8,
  parameter int SKID_DEPTH = 4,
  parameter int CNT_W      = 16,
  parameter int INST_BYTES = 4,
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CW-1:0]           fe_cnt,
  input  logic [SLOTS*PC_W-1:0]   fe_pc,
  input  logic [SLOTS*PC_W-1:0]   fe_pred_npc,
  input  logic [SLOTS*SEQ_W-1:0]  fe_seq,
  input  logic [SLOTS*FLAG_W-1:0] fe_flags,
  input  logic [SLOTS*PC_W-1:0]   fe_target,
  output logic                    fe_stall,
  output logic                    fe_squash,
  output logic                    fe_ctrl_mis,
  output logic [PC_W-1:0]         fe_next_pc,
  output logic [SEQ_W-1:0]        fe_done_seq,
  input  logic                    cm_squash,
  input  logic                    rob_squashing,
  input  logic                    rn_ready,
  output logic [CW-1:0]           rn_cnt,
  output logic [SLOTS*PC_W-1:0]   rn_pc,
  output logic [SLOTS*SEQ_W-1:0]  rn_seq,
  output logic [CNT_W-1:0]        pc_idle,
  output logic [CNT_W-1:0]        pc_blocked,
  output logic [CNT_W-1:0]        pc_unblock,
  output logic [CNT_W-1:0]        pc_squash,
  output logic [CNT_W-1:0]        pc_br_mis,
  output logic [CNT_W-1:0]        pc_ctl_mis,
  output logic [CNT_W-1:0]        pc_decoded,
  output logic [CNT_W-1:0]        pc_squashed
);

  localparam int O_TGT = 0;
  localparam int O_FLG = O_TGT + SLOTS*PC_W;
  localparam int O_SEQ = O_FLG + SLOTS*FLAG_W;
  localparam int O_NPC = O_SEQ + SLOTS*SEQ_W;
  localparam int O_PC  = O_NPC + SLOTS*PC_W;
  localparam int O_CNT = O_PC + SLOTS*PC_W;
  localparam int GRP_W = O_CNT + CW;
  localparam int SCW   = $clog2(SKID_DEPTH + 1);

  dec_state_e state, nxt;

  logic [GRP_W-1:0] grp_in, skid_rd, src;
  logic [SCW-1:0]   skid_cnt;
  logic             push, pop, flush, process;
  logic             any_cs;

  logic [CW-1:0]          k_cnt, s_cnt;
  logic [SLOTS*PC_W-1:0]  k_pc;
  logic [SLOTS*SEQ_W-1:0] k_seq;
  logic                   hit, hit_ctrl;
  logic [PC_W-1:0]        hit_pc;
  logic [SEQ_W-1:0]       hit_seq;

  logic [CW-1:0]    inc [NUM_CTRS];
  logic [CNT_W-1:0] ctr [NUM_CTRS];

  assign grp_in = {fe_cnt, fe_pc, fe_pred_npc, fe_seq, fe_flags, fe_target};
  assign src    = (state == ST_UNBLK) ? skid_rd : grp_in;
  assign any_cs = cm_squash || rob_squashing;

  dec_skid_fifo #(.WIDTH(GRP_W), .DEPTH(SKID_DEPTH)) u_skid (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .flush(flush),
    .wr_data(grp_in), .rd_data(skid_rd), .count(skid_cnt)
  );

  dec_group_scan #(.SLOTS(SLOTS), .PC_W(PC_W), .SEQ_W(SEQ_W),
                   .INST_BYTES(INST_BYTES)) u_scan (
    .in_cnt(src[O_CNT +: CW]),
    .in_pc(src[O_PC +: SLOTS*PC_W]),
    .in_npc(src[O_NPC +: SLOTS*PC_W]),
    .in_seq(src[O_SEQ +: SLOTS*SEQ_W]),
    .in_flags(src[O_FLG +: SLOTS*FLAG_W]),
    .in_tgt(src[O_TGT +: SLOTS*PC_W]),
    .keep_cnt(k_cnt), .keep_pc(k_pc), .keep_seq(k_seq), .skip_cnt(s_cnt),
    .hit(hit), .hit_ctrl(hit_ctrl), .hit_pc(hit_pc), .hit_seq(hit_seq)
  );

  always_comb begin
    nxt     = state;
    push    = 1'b0;
    pop     = 1'b0;
    flush   = 1'b0;
    process = 1'b0;
    unique case (state)
      ST_IDLE, ST_RUN: begin
        if (any_cs) begin
          flush = 1'b1;
          nxt   = ST_SQUASH;
        end else if (!rn_ready) begin
          push = (fe_cnt != '0);
          nxt  = ST_BLOCK;
        end else if (fe_cnt != '0) begin
          process = 1'b1;
          nxt     = hit ? ST_SQUASH : ST_RUN;
        end else begin
          nxt = ST_IDLE;
        end
      end
      ST_BLOCK: begin
        if (any_cs) begin
          flush = 1'b1;
          nxt   = ST_SQUASH;
        end else begin
          push = (fe_cnt != '0);
          if (rn_ready) nxt = (skid_cnt == '0 && !push) ? ST_RUN : ST_UNBLK;
        end
      end
      ST_UNBLK: begin
        if (any_cs) begin
          flush = 1'b1;
          nxt   = ST_SQUASH;
        end else if (!rn_ready) begin
          push = (fe_cnt != '0);
          nxt  = ST_BLOCK;
        end else begin
          push    = (fe_cnt != '0);
          pop     = 1'b1;
          process = 1'b1;
          if (hit) begin
            flush = 1'b1;
            push  = 1'b0;
            nxt   = ST_SQUASH;
          end else if (skid_cnt == SCW'(1) && !push) begin
            nxt = ST_RUN;
          end
        end
      end
      ST_SQUASH: begin
        if (!any_cs) nxt = ST_RUN;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      fe_stall    <= 1'b0;
      fe_squash   <= 1'b0;
      fe_ctrl_mis <= 1'b0;
      fe_next_pc  <= '0;
      fe_done_seq <= '0;
      rn_cnt      <= '0;
      rn_pc       <= '0;
      rn_seq      <= '0;
    end else begin
      state     <= nxt;
      fe_stall  <= (nxt == ST_BLOCK) || (nxt == ST_UNBLK);
      fe_squash <= process && hit;
      if (process && hit) begin
        fe_ctrl_mis <= hit_ctrl;
        fe_next_pc  <= hit_pc;
        fe_done_seq <= hit_seq;
      end
      rn_cnt <= process ? k_cnt : '0;
      if (process) begin
        rn_pc  <= k_pc;
        rn_seq <= k_seq;
      end
    end
  end

  always_comb begin
    inc[CT_IDLE]     = CW'(((state == ST_IDLE) || (state == ST_RUN)) && (fe_cnt == '0));
    inc[CT_BLOCKED]  = CW'(state == ST_BLOCK);
    inc[CT_UNBLOCK]  = CW'(state == ST_UNBLK);
    inc[CT_SQUASH]   = CW'(state == ST_SQUASH);
    inc[CT_BR_MIS]   = CW'(process && hit && !hit_ctrl);
    inc[CT_CTL_MIS]  = CW'(process && hit && hit_ctrl);
    inc[CT_DECODED]  = process ? k_cnt : '0;
    inc[CT_SQUASHED] = process ? s_cnt : '0;
  end

  dec_perf_ctrs #(.NUM(NUM_CTRS), .INC_W(CW), .CNT_W(CNT_W)) u_ctrs (
    .clk(clk), .rst(rst), .inc(inc), .val(ctr)
  );

  assign pc_idle     = ctr[CT_IDLE];
  assign pc_blocked  = ctr[CT_BLOCKED];
  assign pc_unblock  = ctr[CT_UNBLOCK];
  assign pc_squash   = ctr[CT_SQUASH];
  assign pc_br_mis   = ctr[CT_BR_MIS];
  assign pc_ctl_mis  = ctr[CT_CTL_MIS];
  assign pc_decoded  = ctr[CT_DECODED];
  assign pc_squashed = ctr[CT_SQUASHED];

  AST_STALL_COVERS_SKID: assert property (@(posedge clk) disable iff (rst)
    (skid_cnt != '0) |-> fe_stall); // R6
  AST_SQUASH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SQUASH && any_cs) |=> (state == ST_SQUASH)); // R9
  AST_REDIRECT_SQUASHING: assert property (@(posedge clk) disable iff (rst)
    fe_squash |-> (state == ST_SQUASH)); // R7
  AST_FWD_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    (rn_cnt != '0) |-> $past(rn_ready)); // R4
  AST_RN_BOUND: assert property (@(posedge clk) disable iff (rst)
    rn_cnt <= CW'(SLOTS)); // R2
  AST_COMMIT_DROPS_STALL: assert property (@(posedge clk) disable iff (rst)
    (any_cs && state != ST_SQUASH) |=> !fe_stall); // R10

endmodule

// File: tb/dec_stage_ctrl_bench.sv
module dec_stage_ctrl_bench;

  localparam int SLOTS = 4;
  localparam int PC_W  = 32;
  localparam int SEQ_W = 8;
  localparam int CW    = 3;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [CW-1:0]          fe_cnt = '0;
  logic [SLOTS*PC_W-1:0]  fe_pc = '0, fe_pred_npc = '0, fe_target = '0;
  logic [SLOTS*SEQ_W-1:0] fe_seq = '0;
  logic [SLOTS*4-1:0]     fe_flags = '0;
  logic cm_squash = 1'b0, rob_squashing = 1'b0, rn_ready = 1'b1;
  logic fe_stall, fe_squash, fe_ctrl_mis;
  logic [PC_W-1:0]  fe_next_pc;
  logic [SEQ_W-1:0] fe_done_seq;
  logic [CW-1:0]    rn_cnt;
  logic [SLOTS*PC_W-1:0]  rn_pc;
  logic [SLOTS*SEQ_W-1:0] rn_seq;
  logic [CNT_W-1:0] pc_idle, pc_blocked, pc_unblock, pc_squash;
  logic [CNT_W-1:0] pc_br_mis, pc_ctl_mis, pc_decoded, pc_squashed;

  dec_stage_ctrl u_dec_stage_ctrl (
    .clk(clk), .rst(rst), .fe_cnt(fe_cnt), .fe_pc(fe_pc), .fe_pred_npc(fe_pred_npc),
    .fe_seq(fe_seq), .fe_flags(fe_flags), .fe_target(fe_target),
    .fe_stall(fe_stall), .fe_squash(fe_squash), .fe_ctrl_mis(fe_ctrl_mis),
    .fe_next_pc(fe_next_pc), .fe_done_seq(fe_done_seq),
    .cm_squash(cm_squash), .rob_squashing(rob_squashing), .rn_ready(rn_ready),
    .rn_cnt(rn_cnt), .rn_pc(rn_pc), .rn_seq(rn_seq),
    .pc_idle(pc_idle), .pc_blocked(pc_blocked), .pc_unblock(pc_unblock),
    .pc_squash(pc_squash), .pc_br_mis(pc_br_mis), .pc_ctl_mis(pc_ctl_mis),
    .pc_decoded(pc_decoded), .pc_squashed(pc_squashed)
  );

  int n_chk  = 0;
  int n_fail = 0;
  logic done = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic drive(input logic [31:0] base, input logic [7:0] sq,
                       input int cnt, input logic [15:0] flags);
    fe_cnt = CW'(cnt);
    fe_flags = flags;
    for (int i = 0; i < SLOTS; i++) begin
      fe_pc[i*PC_W +: PC_W]       = base + 32'(4*i);
      fe_pred_npc[i*PC_W +: PC_W] = base + 32'(4*i + 4);
      fe_target[i*PC_W +: PC_W]   = base + 32'(4*i + 4);
      fe_seq[i*SEQ_W +: SEQ_W]    = sq + 8'(i);
    end
  endtask

  task automatic no_input();
    fe_cnt = '0;
  endtask

  task automatic t_reset();
    check("R1 stall", 32'(fe_stall), 0);
    check("R1 squash", 32'(fe_squash), 0);
    check("R1 rn_cnt", 32'(rn_cnt), 0);
    check("R1 counters", 32'(pc_idle | pc_blocked | pc_unblock | pc_squash |
          pc_br_mis | pc_ctl_mis | pc_decoded | pc_squashed), 0);
  endtask

  task automatic t_run();
    logic [CNT_W-1:0] d0 = pc_decoded;
    drive(32'h1000, 8'h10, 4, 16'h0E00);
    step();
    no_input();
    check("R2 count", 32'(rn_cnt), 4);
    check("R2 slot0 pc", rn_pc[31:0], 32'h1000);
    check("R2 slot3 pc", rn_pc[127:96], 32'h100C);
    check("R2 slot2 seq", 32'(rn_seq[23:16]), 32'h12);
    check("R2 no redirect on good resolve", 32'(fe_squash), 0);
    check("R12 decoded", 32'(pc_decoded - d0), 4);
    step();
    check("R2 idle output", 32'(rn_cnt), 0);
  endtask

  task automatic t_skip();
    logic [CNT_W-1:0] s0 = pc_squashed;
    logic [CNT_W-1:0] d0 = pc_decoded;
    drive(32'h2000, 8'h20, 4, 16'h1010);
    step();
    no_input();
    check("R3 count", 32'(rn_cnt), 2);
    check("R3 slot0", rn_pc[31:0], 32'h2000);
    check("R3 slot1", rn_pc[63:32], 32'h2008);
    check("R3 squashed ctr", 32'(pc_squashed - s0), 2);
    check("R12 decoded", 32'(pc_decoded - d0), 2);
    step();
  endtask

  task automatic t_idle();
    logic [CNT_W-1:0] i0 = pc_idle;
    no_input();
    step(); step(); step();
    check("R11 idle ctr", 32'(pc_idle - i0), 3);
  endtask

  task automatic t_block_empty();
    rn_ready = 1'b0;
    no_input();
    step();
    check("R4 stall on not ready", 32'(fe_stall), 1);
    rn_ready = 1'b1;
    step();
    check("R4 stall released", 32'(fe_stall), 0);
    check("R4 nothing out", 32'(rn_cnt), 0);
  endtask

  task automatic t_block_drain();
    logic [CNT_W-1:0] b0 = pc_blocked;
    logic [CNT_W-1:0] u0 = pc_unblock;
    rn_ready = 1'b0;
    drive(32'h3000, 8'h30, 4, 16'h0);
    step();
    check("R4 stall", 32'(fe_stall), 1);
    check("R4 held from rename", 32'(rn_cnt), 0);
    drive(32'h3100, 8'h40, 4, 16'h0);
    step();
    check("R5 stall held", 32'(fe_stall), 1);
    drive(32'h3200, 8'h50, 4, 16'h0);
    step();
    rn_ready = 1'b1;
    drive(32'h3300, 8'h60, 4, 16'h0);
    step();
    check("R5 stall held full", 32'(fe_stall), 1);
    check("R5 no output", 32'(rn_cnt), 0);
    drive(32'h3400, 8'h70, 3, 16'h0);
    step();
    no_input();
    check("R6 g1 pc", rn_pc[31:0], 32'h3000);
    check("R6 g1 seq", 32'(rn_seq[7:0]), 32'h30);
    check("R6 stall", 32'(fe_stall), 1);
    step();
    check("R6 g2 pc", rn_pc[31:0], 32'h3100);
    step();
    check("R6 g3 pc", rn_pc[31:0], 32'h3200);
    step();
    check("R6 g4 pc", rn_pc[31:0], 32'h3300);
    check("R6 stall before last", 32'(fe_stall), 1);
    step();
    check("R6 g5 pc", rn_pc[31:0], 32'h3400);
    check("R6 g5 count", 32'(rn_cnt), 3);
    check("R6 stall released", 32'(fe_stall), 0);
    check("R11 blocked ctr", 32'(pc_blocked - b0), 3);
    check("R11 unblock ctr", 32'(pc_unblock - u0), 5);
    step();
    check("R6 drained", 32'(rn_cnt), 0);
  endtask

  task automatic t_branch();
    logic [CNT_W-1:0] b0 = pc_br_mis;
    logic [CNT_W-1:0] q0 = pc_squash;
    logic [CNT_W-1:0] d0 = pc_decoded;
    drive(32'h4000, 8'h80, 4, 16'h0060);
    fe_target[63:32] = 32'h9000;
    step();
    drive(32'h4100, 8'h90, 4, 16'h0);
    check("R7 truncated count", 32'(rn_cnt), 2);
    check("R7 branch forwarded", rn_pc[63:32], 32'h4004);
    check("R7 squash pulse", 32'(fe_squash), 1);
    check("R7 next pc", fe_next_pc, 32'h9000);
    check("R7 seq", 32'(fe_done_seq), 32'h81);
    check("R7 cause", 32'(fe_ctrl_mis), 0);
    check("R7 br ctr", 32'(pc_br_mis - b0), 1);
    check("R12 decoded", 32'(pc_decoded - d0), 2);
    step();
    no_input();
    check("R9 group dropped", 32'(rn_cnt), 0);
    check("R7 pulse ends", 32'(fe_squash), 0);
    check("R11 squash ctr", 32'(pc_squash - q0), 1);
    drive(32'h4200, 8'hA0, 1, 16'h0);
    step();
    no_input();
    check("R9 running again", rn_pc[31:0], 32'h4200);
    step();
  endtask

  task automatic t_ctrl();
    logic [CNT_W-1:0] c0 = pc_ctl_mis;
    drive(32'h5000, 8'hB0, 3, 16'h0008);
    step();
    no_input();
    check("R8 count", 32'(rn_cnt), 1);
    check("R8 squash", 32'(fe_squash), 1);
    check("R8 next pc", fe_next_pc, 32'h5004);
    check("R8 cause", 32'(fe_ctrl_mis), 1);
    check("R8 ctr", 32'(pc_ctl_mis - c0), 1);
    step();
  endtask

  task automatic t_commit();
    logic [CNT_W-1:0] q0;
    drive(32'h6000, 8'hC0, 4, 16'h0);
    cm_squash = 1'b1;
    step();
    no_input();
    cm_squash = 1'b0;
    check("R10 running group dropped", 32'(rn_cnt), 0);
    step();
    rn_ready = 1'b0;
    drive(32'h6100, 8'hD0, 4, 16'h0);
    step();
    drive(32'h6200, 8'hE0, 4, 16'h0);
    step();
    no_input();
    rn_ready = 1'b1;
    cm_squash = 1'b1;
    q0 = pc_squash;
    step();
    check("R10 stall dropped", 32'(fe_stall), 0);
    step();
    cm_squash = 1'b0;
    rob_squashing = 1'b1;
    step();
    check("R9 held by rob", 32'(rn_cnt), 0);
    rob_squashing = 1'b0;
    step();
    step();
    check("R10 parked flushed", 32'(rn_cnt), 0);
    check("R11 squash ctr", 32'(pc_squash - q0), 3);
    drive(32'h6300, 8'hF0, 2, 16'h0);
    step();
    no_input();
    check("R10 fresh group", rn_pc[63:32], 32'h6304);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    t_reset();
    t_run();
    t_skip();
    t_idle();
    t_block_empty();
    t_block_drain();
    t_branch();
    t_ctrl();
    t_commit();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule